// File: doc/BRIEF.md
# Multichannel ADC Data Simulator

This block sits on the data path between a group of video converter interfaces and the acquisition buffer. A conversion strobe captures one sample from every channel. The block then sends the captured words out on a single word-wide port, one channel per cycle, with a valid flag on each word. While the data path is being brought up without a detector, a run-time mode makes the block replace the real samples with synthetic words. Downstream logic can then check the ordering and count of the words.

There are two synthetic patterns. In the first, every word carries the index of its own channel. In the second, every word of a group carries a shared counter that advances once per accepted strobe. The mode sits in a small register that software writes. A mode written there takes effect at the next accepted strobe, so a group never mixes two modes.

Top module: `adc_sim_mux`

## Requirements
- R1: After reset, out_valid is 0, the pending and effective modes are pass-through (code 2'b00), and the counter is zero.
- R2: A strobe sampled while no group is in progress starts a group. Valid words appear on the NCH cycles that follow the sampling edge, with out_chan equal to 0, 1, ..., NCH-1 in order. out_valid is low in the cycle after the last word.
- R3: In mode 2'b00, word k equals adc_data[k*WIDTH +: WIDTH] as sampled at the strobe edge. Later changes of adc_data do not alter the group.
- R4: In mode 2'b01, word k equals k, zero-extended to WIDTH bits.
- R5: In mode 2'b10, every word of a group carries the same counter value. The counter advances by one for each accepted strobe and wraps modulo 2^WIDTH.
- R6: Mode code 2'b11 is reserved and produces the same words as pass-through.
- R7: A mode written through mode_wr/mode_wdata becomes effective only at the next accepted strobe. A group already in progress keeps its mode.
- R8: The counter counts accepted strobes in every mode. When the effective mode changes at a strobe, the counter restarts, so that group shows 0 and the next one shows 1.
- R9: A strobe that arrives while a group is in progress is ignored. It captures no data, does not advance the counter and does not alter the words being sent.
- R10: The sample width is the parameter WIDTH (16 or 18 in use).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Write enable for the mode register |
| mode_wdata | input | 2 | Mode code: 00 pass, 01 channel index, 10 counter, 11 pass |
| conv_strobe | input | 1 | Conversion strobe, one cycle per conversion |
| adc_data | input | NCH*WIDTH | Converter samples, channel k at bits k*WIDTH +: WIDTH |
| out_valid | output | 1 | Word on out_data is valid |
| out_chan | output | $clog2(NCH) | Channel index of the current word |
| out_data | output | WIDTH | Sample or synthetic word |

## Verification
The assertions take it that reset is held low for at least one edge. Apart from that, they expect no input discipline. Stray strobes during a group and mode writes at any time are legal, and the properties state that the group sequence, its effective mode and its counter stay undisturbed by them. The stimulus drives these cases on purpose: random mode writes land mid-group and between groups, extra strobes fall inside groups, and adc_data is scrambled right after each capture. A second, narrow instance lets the counter wrap within the run time.

// File: rtl/adc_sim_mux.sv
module adc_sim_mux #(
  parameter int WIDTH = 16,
  parameter int NCH   = 4,
  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_wr,
  input  logic [1:0]           mode_wdata,
  input  logic                 conv_strobe,
  input  logic [NCH*WIDTH-1:0] adc_data,
  output logic                 out_valid,
  output logic [IW-1:0]        out_chan,
  output logic [WIDTH-1:0]     out_data
);

  localparam logic [1:0] M_CHAN = 2'b01;
  localparam logic [1:0] M_CNT  = 2'b10;

  logic [1:0]            mode_q;
  logic [1:0]            act_mode;
  logic [WIDTH-1:0]      cnt;
  logic [WIDTH-1:0]      snap;
  logic                  busy;
  logic [IW-1:0]         idx;
  logic [WIDTH-1:0]      buf_q [NCH];

  wire accept   = conv_strobe & ~busy;
  wire mode_chg = mode_q != act_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= 2'b00;
      act_mode <= 2'b00;
      cnt      <= '0;
      snap     <= '0;
      busy     <= 1'b0;
      idx      <= '0;
      for (int i = 0; i < NCH; i++) buf_q[i] <= '0;
    end else begin
      if (mode_wr) mode_q <= mode_wdata;
      if (accept) begin
        busy     <= 1'b1;
        idx      <= '0;
        act_mode <= mode_q;
        for (int i = 0; i < NCH; i++) buf_q[i] <= adc_data[i*WIDTH +: WIDTH];
        if (mode_chg) begin
          snap <= '0;
          cnt  <= WIDTH'(1);
        end else begin
          snap <= cnt;
          cnt  <= cnt + WIDTH'(1);
        end
      end else if (busy) begin
        idx <= idx + IW'(1);
        if (idx == IW'(NCH-1)) busy <= 1'b0;
      end
    end
  end

  assign out_valid = busy;
  assign out_chan  = idx;

  always_comb begin
    case (act_mode)
      M_CHAN:  out_data = WIDTH'(idx);
      M_CNT:   out_data = snap;
      default: out_data = buf_q[idx];
    endcase
  end

endmodule

// File: rtl/adc_sim_mux_chk.sv
module adc_sim_mux_chk #(
  parameter int WIDTH = 16,
  parameter int NCH   = 4,
  parameter int IW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_strobe,
  input logic             out_valid,
  input logic [IW-1:0]    out_chan,
  input logic [WIDTH-1:0] out_data,
  input logic [1:0]       act_mode,
  input logic [WIDTH-1:0] cnt
);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && conv_strobe |=> out_valid && out_chan == '0);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_chan != IW'(NCH-1) |=> out_valid && out_chan == $past(out_chan) + IW'(1));

  p_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_chan == IW'(NCH-1) |=> !out_valid);

  p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_chan != '0 |-> $stable(act_mode));

  p_cnt_shared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_chan != '0 && act_mode == 2'b10 |-> $stable(out_data));

  p_stray_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_chan != '0 |-> $stable(cnt));

  p_idle_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !out_valid && cnt == '0);

endmodule

bind adc_sim_mux adc_sim_mux_chk #(.WIDTH(WIDTH), .NCH(NCH), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_strobe(conv_strobe), .out_valid(out_valid),
  .out_chan(out_chan), .out_data(out_data), .act_mode(act_mode), .cnt(cnt)
);

// File: tb/adc_sim_mux_bench.sv
module adc_sim_mux_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int N = 4;
  localparam int SW = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic mode_wr = 0;
  logic [1:0] mode_wdata = 0;
  logic conv_strobe = 0;
  logic [N*W-1:0] adc_data = 0;
  logic out_valid;
  logic [1:0] out_chan;
  logic [W-1:0] out_data;

  logic s_mode_wr = 0;
  logic [1:0] s_mode_wdata = 0;
  logic s_strobe = 0;
  logic s_valid;
  logic [1:0] s_chan;
  logic [SW-1:0] s_data;

  int n_chk = 0;
  int n_fail = 0;

  logic [1:0] m_pend = 0, m_eff = 0;
  logic [W-1:0] m_cnt = 0, m_snap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_sim_mux #(.WIDTH(W), .NCH(N)) u_adc_sim_mux (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .conv_strobe(conv_strobe), .adc_data(adc_data), .out_valid(out_valid),
    .out_chan(out_chan), .out_data(out_data));

  adc_sim_mux #(.WIDTH(SW), .NCH(N)) u_small (
    .clk(clk), .rst_n(rst_n), .mode_wr(s_mode_wr), .mode_wdata(s_mode_wdata),
    .conv_strobe(s_strobe), .adc_data('0), .out_valid(s_valid),
    .out_chan(s_chan), .out_data(s_data));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_word(input logic [1:0] m, input int k,
                                            input logic [N*W-1:0] d, input logic [W-1:0] s);
    case (m)
      2'b01:   return W'(k);
      2'b10:   return s;
      default: return d[k*W +: W];
    endcase
  endfunction

  task automatic write_mode(input logic [1:0] m);
    @(negedge clk); mode_wr = 1; mode_wdata = m;
    @(negedge clk); mode_wr = 0;
    m_pend = m;
  endtask

  task automatic group(input string req, input logic [N*W-1:0] d,
                       input bit stray, input bit midw, input logic [1:0] mw);
    @(negedge clk); adc_data = d; conv_strobe = 1;
    @(posedge clk);
    if (m_pend != m_eff) begin m_eff = m_pend; m_snap = 0; m_cnt = 1; end
    else begin m_snap = m_cnt; m_cnt = m_cnt + 1; end
    @(negedge clk); conv_strobe = 0; adc_data = {$urandom, $urandom};
    for (int k = 0; k < N; k++) begin
      chk({req, " R2 valid"}, 64'(out_valid), 64'd1);
      chk({req, " R2 chan"}, 64'(out_chan), 64'(k));
      chk(req, 64'(out_data), 64'(exp_word(m_eff, k, d, m_snap)));
      if (k == 1) begin
        if (stray) conv_strobe = 1;
        if (midw) begin mode_wr = 1; mode_wdata = mw; end
      end
      if (k == 2) begin
        conv_strobe = 0;
        if (midw) begin mode_wr = 0; m_pend = mw; end
      end
      @(negedge clk);
    end
    chk("R2 idle after group", 64'(out_valid), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", 64'(out_valid), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle", 64'(out_valid), 64'd0);

    group("R1 R3 default pass", 64'h1111_2222_3333_4444, 0, 0, 0);
    group("R3 pass", 64'hdead_beef_0123_4567, 0, 0, 0);
    write_mode(2'b01);
    group("R4 chan mode", 64'hffff_ffff_ffff_ffff, 0, 0, 0);
    write_mode(2'b10);
    group("R8 R5 counter first", 64'h0, 0, 0, 0);
    group("R5 counter second", 64'h0, 0, 0, 0);
    group("R9 R5 stray strobe", 64'h0, 1, 0, 0);
    group("R5 counter after stray", 64'h0, 0, 0, 0);
    write_mode(2'b11);
    group("R6 reserved pass", 64'h0a0b_0c0d_0e0f_1234, 0, 0, 0);
    write_mode(2'b10);
    group("R8 counter cleared", 64'h0, 0, 0, 0);
    write_mode(2'b10);
    group("R8 same mode keeps", 64'h0, 0, 0, 0);
    group("R7 midgroup write", 64'h0, 0, 1, 2'b01);
    group("R7 write applied", 64'h5555_6666_7777_8888, 0, 0, 0);

    for (int g = 0; g < 60; g++) begin
      if ($urandom % 3 == 0) write_mode(2'($urandom));
      group("R10 R3 random", {$urandom, $urandom}, bit'($urandom), bit'($urandom), 2'($urandom));
    end

    @(negedge clk); s_mode_wr = 1; s_mode_wdata = 2'b10;
    @(negedge clk); s_mode_wr = 0;
    for (int g = 0; g < 17; g++) begin
      @(negedge clk); s_strobe = 1;
      @(negedge clk); s_strobe = 0;
      chk("R5 wrap valid", 64'(s_valid), 64'd1);
      chk("R5 wrap value", 64'(s_data), 64'(g % 16));
      repeat (N) @(negedge clk);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule